// File: doc/BRIEF.md
# IPv4 Header Check and TTL Update Stage

This stage sits in the per-packet fast path of a forwarding engine. Each transfer carries one complete 20-byte IPv4 fixed header as a 160-bit vector, with byte 0 in bits 159:152. Alongside the header come the packet length reported by the link layer and a flag that says whether a previous stage matched the destination against one of the router's own addresses. The stage checks that the header is well formed and applies the hop-limit rules. For transit traffic it decrements TTL and patches the header checksum in place, using one small addition instead of summing the header again.

The result has four parts: a verdict (forward, deliver to the local control processor, or drop), a drop reason, a request for a time-exceeded notification, and the header to pass downstream. Input and output each use a valid/ready handshake. Every accepted header yields exactly one result, registered one cycle after acceptance. IP options, fragmentation, route lookup and building the notification packet belong to other stages.

Top module: `ipv4_hdr_fastpath`

## Requirements
- R1: A header whose version nibble (bits 159:156) is not 4 is dropped (verdict 2) with reason 0.
- R2: A packet whose link-layer length is below 20 bytes is dropped with reason 1.
- R3: A header whose length nibble (bits 155:152) is below 5, or whose length in bytes (nibble times 4) exceeds the link-layer length, is dropped with reason 1.
- R4: A header whose ten 16-bit words do not fold under one's-complement addition to 0xFFFF is dropped with reason 2.
- R5: A valid header flagged as locally addressed is delivered locally (verdict 1) for every TTL from 0 to 255, and its header leaves the stage unchanged.
- R6: A valid transit header with TTL (byte 8, bits 95:88) of 2 or more is forwarded (verdict 0). Its TTL is reduced by one, and only the TTL and checksum (bytes 10 and 11, bits 79:64) bytes change.
- R7: A valid transit header with TTL 0 or 1 is dropped with reason 3, and the notification request output is high. That output is low for every other result.
- R8: The forwarded checksum is the old checksum plus 0x0100 with end-around carry. It matches a full recomputation over the modified header, with 0x0000 and 0xFFFF taken as equal, and this holds when the addition wraps.
- R9: When several checks fail, the reason reported follows the priority version over length over checksum over TTL.
- R10: The result of an accepted header appears one cycle after acceptance. While the output is valid and not taken, all outputs hold steady and the input is not ready.
- R11: After reset the output is not valid and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Header transfer offered |
| in_ready_o | output | 1 | Stage can accept a header |
| hdr_i | input | 160 | IPv4 fixed header, byte 0 in bits 159:152 |
| link_len_i | input | LEN_W | Packet length in bytes from the link layer |
| dst_local_i | input | 1 | Destination is a router-owned address |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Downstream takes the result |
| verdict_o | output | 2 | 0 forward, 1 deliver local, 2 drop |
| reason_o | output | 2 | Drop cause: 0 version, 1 length, 2 checksum, 3 TTL expired |
| icmp_req_o | output | 1 | Time-exceeded notification requested |
| hdr_o | output | 160 | Header after the TTL and checksum update |

## Verification
The only state in the stage is the single result register, so a fault there shows at the ports in the very next cycle after acceptance. It shows as a wrong verdict or reason, as a header whose fold is not 0xFFFF, or as an output that shifts while downstream stalls. A flaw in the checksum patch hides in most headers. It surfaces only when the high byte of the old checksum is 0xFF, so those wrapping cases are searched for on purpose and compared with a full recomputation. TTL is swept over its whole range for both local and transit traffic, and the version nibble, the length nibble and the link length are each swept across their boundaries.

// File: rtl/ipv4_fp_pkg.sv
package ipv4_fp_pkg;
  localparam int HDR_BYTES = 20;
  localparam int HDR_W     = HDR_BYTES * 8;
  localparam int WORD_W    = 16;
  localparam int N_WORDS   = HDR_W / WORD_W;
  localparam int MIN_LEN   = HDR_BYTES;
  localparam int TTL_LSB   = HDR_W - 8 * 9;   // byte 8
  localparam int CS_LSB    = HDR_W - 8 * 12;  // bytes 10..11

  typedef enum logic [1:0] {
    VERD_FWD   = 2'd0,
    VERD_LOCAL = 2'd1,
    VERD_DROP  = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    RSN_VERSION = 2'd0,
    RSN_LENGTH  = 2'd1,
    RSN_CSUM    = 2'd2,
    RSN_TTL     = 2'd3
  } reason_e;

  typedef struct packed {
    verdict_e verdict;
    reason_e  reason;
    logic     icmp;
  } decision_t;
endpackage

// File: rtl/ipv4_csum_fold.sv
module ipv4_csum_fold #(
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 10
) (
  input  logic [WORD_W*N_WORDS-1:0] words_i,
  output logic [WORD_W-1:0]         sum_o
);
  localparam int ACC_W = WORD_W + $clog2(N_WORDS) + 1;

  logic [ACC_W-1:0] part [N_WORDS+1];
  logic [WORD_W:0]  fold1;
  logic [WORD_W:0]  fold2;

  assign part[0] = '0;
  for (genvar i = 0; i < N_WORDS; i++) begin : g_acc
    assign part[i+1] = part[i] + ACC_W'(words_i[i*WORD_W +: WORD_W]);
  end

  assign fold1 = (WORD_W+1)'(part[N_WORDS][WORD_W-1:0])
               + (WORD_W+1)'(part[N_WORDS][ACC_W-1:WORD_W]);
  assign fold2 = (WORD_W+1)'(fold1[WORD_W-1:0]) + (WORD_W+1)'(fold1[WORD_W]);
  assign sum_o = fold2[WORD_W-1:0];
endmodule

// File: rtl/ipv4_hdr_check.sv
module ipv4_hdr_check
  import ipv4_fp_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [3:0]        version_i,
  input  logic [3:0]        ihl_i,
  input  logic [LEN_W-1:0]  link_len_i,
  input  logic [WORD_W-1:0] fold_i,
  input  logic [7:0]        ttl_i,
  input  logic              dst_local_i,
  output decision_t         dec_o
);
  logic [LEN_W-1:0] hdr_bytes;
  logic bad_ver, bad_len, bad_cs, expired;

  assign hdr_bytes = LEN_W'({ihl_i, 2'b00});
  assign bad_ver   = version_i != 4'd4;
  assign bad_len   = (link_len_i < LEN_W'(MIN_LEN)) || (ihl_i < 4'd5)
                   || (hdr_bytes > link_len_i);
  assign bad_cs    = fold_i != {WORD_W{1'b1}};
  // transit TTL after decrement must stay positive
  assign expired   = ttl_i <= 8'd1;

  always_comb begin
    dec_o = '{verdict: VERD_FWD, reason: RSN_VERSION, icmp: 1'b0};
    if (bad_ver) begin
      dec_o.verdict = VERD_DROP;
      dec_o.reason  = RSN_VERSION;
    end else if (bad_len) begin
      dec_o.verdict = VERD_DROP;
      dec_o.reason  = RSN_LENGTH;
    end else if (bad_cs) begin
      dec_o.verdict = VERD_DROP;
      dec_o.reason  = RSN_CSUM;
    end else if (dst_local_i) begin
      dec_o.verdict = VERD_LOCAL;
    end else if (expired) begin
      dec_o.verdict = VERD_DROP;
      dec_o.reason  = RSN_TTL;
      dec_o.icmp    = 1'b1;
    end
  end
endmodule

// File: rtl/ipv4_ttl_patch.sv
module ipv4_ttl_patch
  import ipv4_fp_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_i,
  output logic [HDR_W-1:0] hdr_o
);
  logic [WORD_W-1:0] cs_old;
  logic [WORD_W:0]   cs_sum;
  logic [WORD_W-1:0] cs_new;
  logic [7:0]        ttl_new;

  assign cs_old  = hdr_i[CS_LSB +: WORD_W];
  // TTL is the high byte of its word: a decrement of one adds 0x0100 to the checksum
  assign cs_sum  = {1'b0, cs_old} + (WORD_W+1)'(16'h0100);
  assign cs_new  = cs_sum[WORD_W-1:0] + WORD_W'(cs_sum[WORD_W]);
  assign ttl_new = hdr_i[TTL_LSB +: 8] - 8'd1;

  always_comb begin
    hdr_o = hdr_i;
    hdr_o[TTL_LSB +: 8]     = ttl_new;
    hdr_o[CS_LSB +: WORD_W] = cs_new;
  end
endmodule

// File: rtl/ipv4_hdr_fastpath.sv
module ipv4_hdr_fastpath
  import ipv4_fp_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [HDR_W-1:0]     hdr_i,
  input  logic [LEN_W-1:0]     link_len_i,
  input  logic                 dst_local_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [1:0]           verdict_o,
  output logic [1:0]           reason_o,
  output logic                 icmp_req_o,
  output logic [HDR_W-1:0]     hdr_o
);
  logic [WORD_W-1:0] fold;
  logic [HDR_W-1:0]  hdr_patched;
  logic [HDR_W-1:0]  hdr_next;
  decision_t         dec;

  logic              valid_q;
  decision_t         dec_q;
  logic [HDR_W-1:0]  hdr_q;

  ipv4_csum_fold #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_fold (
    .words_i (hdr_i),
    .sum_o   (fold)
  );

  ipv4_hdr_check #(.LEN_W(LEN_W)) u_check (
    .version_i   (hdr_i[HDR_W-1 -: 4]),
    .ihl_i       (hdr_i[HDR_W-5 -: 4]),
    .link_len_i  (link_len_i),
    .fold_i      (fold),
    .ttl_i       (hdr_i[TTL_LSB +: 8]),
    .dst_local_i (dst_local_i),
    .dec_o       (dec)
  );

  ipv4_ttl_patch u_patch (
    .hdr_i (hdr_i),
    .hdr_o (hdr_patched)
  );

  assign hdr_next   = (dec.verdict == VERD_FWD) ? hdr_patched : hdr_i;
  assign in_ready_o = !valid_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dec_q   <= '{verdict: VERD_FWD, reason: RSN_VERSION, icmp: 1'b0};
      hdr_q   <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) begin
        dec_q <= dec;
        hdr_q <= hdr_next;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign verdict_o   = dec_q.verdict;
  assign reason_o    = dec_q.reason;
  assign icmp_req_o  = dec_q.icmp;
  assign hdr_o       = hdr_q;
endmodule

// File: rtl/ipv4_fp_chk.sv
module ipv4_fp_chk
  import ipv4_fp_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [HDR_W-1:0] hdr_i,
  input logic             dst_local_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [1:0]       verdict_o,
  input logic [1:0]       reason_o,
  input logic             icmp_req_o,
  input logic [HDR_W-1:0] hdr_o
);
  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(hdr_o)
      && $stable(verdict_o) && $stable(reason_o) && $stable(icmp_req_o));

  // R10
  accept_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  // R10
  stall_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  // R7
  icmp_reason_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && icmp_req_o |-> verdict_o == 2'd2 && reason_o == 2'd3);

  // R6
  fwd_ttl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && verdict_o == 2'd0 |-> hdr_o[TTL_LSB +: 8] != 8'd0);

  // R5
  local_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && dst_local_i |=>
      verdict_o != 2'd1 || hdr_o == $past(hdr_i));

  // R1
  verdict_enc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> verdict_o != 2'd3);
endmodule

bind ipv4_hdr_fastpath ipv4_fp_chk #(.LEN_W(LEN_W)) u_fp_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .hdr_i       (hdr_i),
  .dst_local_i (dst_local_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .verdict_o   (verdict_o),
  .reason_o    (reason_o),
  .icmp_req_o  (icmp_req_o),
  .hdr_o       (hdr_o)
);

// File: tb/test_ipv4_hdr_fastpath.sv
`timescale 1ns/1ps
module test_ipv4_hdr_fastpath;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic [159:0] hdr_i = '0;
  logic [LEN_W-1:0] link_len_i = '0;
  logic dst_local_i = 1'b0;
  logic out_valid_o;
  logic out_ready_i = 1'b1;
  logic [1:0] verdict_o, reason_o;
  logic icmp_req_o;
  logic [159:0] hdr_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipv4_hdr_fastpath #(.LEN_W(LEN_W)) i_ipv4_hdr_fastpath (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .hdr_i(hdr_i), .link_len_i(link_len_i), .dst_local_i(dst_local_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .verdict_o(verdict_o),
    .reason_o(reason_o), .icmp_req_o(icmp_req_o), .hdr_o(hdr_o)
  );

  function automatic logic [15:0] fsum(input logic [159:0] h);
    int unsigned s = 0;
    for (int i = 0; i < 10; i++) s += h[i*16 +: 16];
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  function automatic logic [159:0] seal(input logic [159:0] h);
    logic [159:0] r = h;
    r[79:64] = 16'h0;
    r[79:64] = ~fsum(r);
    return r;
  endfunction

  function automatic logic [159:0] mk(input logic [3:0] ver, input logic [3:0] ihl,
                                      input logic [7:0] ttl);
    logic [159:0] h;
    for (int i = 0; i < 5; i++) h[i*32 +: 32] = $urandom;
    h[159:156] = ver;
    h[155:152] = ihl;
    h[95:88] = ttl;
    return seal(h);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected decision from the requirement list
  task automatic expect_dec(input logic [159:0] h, input int len, input bit loc,
                            output int v, output int r, output bit ic);
    ic = 0; r = 0; v = 2;
    if (h[159:156] != 4) r = 0;
    else if (len < 20 || h[155:152] < 5 || h[155:152] * 4 > len) r = 1;
    else if (fsum(h) != 16'hFFFF) r = 2;
    else if (loc) v = 1;
    else if (h[95:88] <= 1) begin r = 3; ic = 1; end
    else v = 0;
  endtask

  task automatic apply(input logic [159:0] h, input int len, input bit loc,
                       input string req);
    int v, r;
    bit ic;
    logic [159:0] ref_h;
    logic [15:0] full_cs;
    @(negedge clk);
    hdr_i = h; link_len_i = LEN_W'(len); dst_local_i = loc; in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    expect_dec(h, len, loc, v, r, ic);
    chk(out_valid_o == 1'b1, "R10", "out_valid", 160'(out_valid_o), 160'd1);
    chk(verdict_o == v[1:0], req, "verdict", 160'(verdict_o), 160'(v));
    if (v == 2) chk(reason_o == r[1:0], req, "reason", 160'(reason_o), 160'(r));
    chk(icmp_req_o == ic, "R7", "icmp_req", 160'(icmp_req_o), 160'(ic));
    if (v == 0) begin
      ref_h = h;
      ref_h[95:88] = h[95:88] - 8'd1;
      ref_h[79:64] = hdr_o[79:64];
      chk(hdr_o == ref_h, "R6", "header fields", hdr_o, ref_h);
      ref_h[79:64] = 16'h0;
      full_cs = ~fsum(ref_h);
      chk(hdr_o[79:64] == full_cs ||
          (hdr_o[79:64] == 16'hFFFF && full_cs == 16'h0000) ||
          (hdr_o[79:64] == 16'h0000 && full_cs == 16'hFFFF),
          "R8", "checksum", 160'(hdr_o[79:64]), 160'(full_cs));
      chk(fsum(hdr_o) == 16'hFFFF, "R8", "fold of output", 160'(fsum(hdr_o)), 160'hFFFF);
    end else begin
      chk(hdr_o == h, (v == 1) ? "R5" : req, "header passthrough", hdr_o, h);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [159:0] h, a, b;
    #10;
    // R11 reset state
    chk(out_valid_o == 1'b0, "R11", "out_valid in reset", 160'(out_valid_o), 160'd0);
    chk(in_ready_o == 1'b1, "R11", "in_ready in reset", 160'(in_ready_o), 160'd1);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R11", "out_valid after reset", 160'(out_valid_o), 160'd0);

    // R5, R6, R7: full TTL sweep, transit and local
    for (int t = 0; t < 256; t++) begin
      apply(mk(4, 5, t[7:0]), 20 + (t % 40), 1'b0, "R6");
      apply(mk(4, 5, t[7:0]), 20 + (t % 40), 1'b1, "R5");
    end
    // R1 version sweep
    for (int ver = 0; ver < 16; ver++) apply(mk(ver[3:0], 5, 64), 60, 1'b0, "R1");
    // R3 length nibble sweep against two link lengths
    for (int ihl = 0; ihl < 16; ihl++) begin
      apply(mk(4, ihl[3:0], 9), 20, 1'b0, "R3");
      apply(mk(4, ihl[3:0], 9), 47, 1'b0, "R3");
    end
    // R2 link length sweep
    for (int len = 0; len <= 40; len++) apply(mk(4, 5, 33), len, len[0], "R2");
    // R4 corrupted bit outside version, length nibble and TTL
    for (int k = 0; k < 64; k++) begin
      h = mk(4, 5, 20 + k[7:0]);
      h[$urandom_range(0, 63)] ^= 1'b1;
      apply(h, 20, k[0], "R4");
    end
    // R9 priority
    apply(mk(6, 2, 0), 10, 1'b0, "R9");
    h = mk(4, 3, 0); h[0] ^= 1'b1;
    apply(h, 12, 1'b0, "R9");
    h = mk(4, 5, 0); h[7] ^= 1'b1;
    apply(h, 20, 1'b0, "R9");
    h = mk(4, 5, 1); h[3] ^= 1'b1;
    apply(h, 20, 1'b1, "R9");
    // R8 checksum high byte 0xFF: the patch wraps its carry
    for (int n = 0; n < 24; n++) begin
      h = mk(4, 5, 2 + n[7:0]);
      for (int tries = 0; tries < 20000 && h[79:72] != 8'hFF; tries++)
        h = mk(4, 5, 2 + n[7:0]);
      apply(h, 20, 1'b0, "R8");
    end
    // R10 backpressure
    a = mk(4, 5, 77);
    b = mk(4, 5, 1);
    @(negedge clk);
    out_ready_i = 1'b0;
    hdr_i = a; link_len_i = 20; dst_local_i = 1'b0; in_valid_i = 1'b1;
    @(negedge clk);
    hdr_i = b;
    chk(in_ready_o == 1'b0, "R10", "in_ready while stalled", 160'(in_ready_o), 160'd0);
    repeat (3) @(negedge clk);
    chk(out_valid_o == 1'b1 && verdict_o == 2'd0, "R10", "held verdict",
        160'(verdict_o), 160'd0);
    chk(hdr_o[95:88] == 8'd76, "R10", "held header TTL", 160'(hdr_o[95:88]), 160'd76);
    out_ready_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    chk(out_valid_o == 1'b1 && verdict_o == 2'd2 && reason_o == 2'd3, "R10",
        "second result after release", 160'({verdict_o, reason_o}), 160'({2'd2, 2'd3}));
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R10", "one result per header", 160'(out_valid_o), 160'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule